// File: doc/BRIEF.md
# Exception State Register Bank

This block is the small privileged register bank that a processor core updates when it takes an exception or interrupt. The bank has four registers. The first is a saved program counter that points back at the instruction that trapped. The second is a cause word, which holds a numeric exception code next to a set of pending-interrupt flags. The third is a status word, which holds an interrupt mask and a three-deep stack of mode/enable pairs. The fourth is a faulting-address register, which records the memory address behind an address or bus fault.

The core pulses a take strobe together with a cause code, the current program counter and the address that faulted. The bank saves the program counter less one instruction step and records the code. It then pushes the status stack so that the core runs in kernel mode with interrupts disabled. A return strobe pops the stack again.

External request lines set sticky pending flags whether or not interrupts are enabled. A masked, enable-gated request output tells the core when to take an interrupt. Privileged software reads and writes the bank through a single register port addressed by register number. On that port, the fields that hardware owns are read-only.

Top module: `exc_state_regs`

## Requirements
- R1: After reset, all four registers read 0. The core is in kernel mode with interrupts disabled (`user_o`=0, `irq_en_o`=0), and `irq_o` is 0.
- R2: On a cycle with `take_i`=1, the saved PC (register 14) becomes `pc_i`-4 at the next edge, and cause bits 5:2 become `code_i`. Cause bits 1:0 and 7:6 always read 0.
- R3: On `take_i`, status bits 5:0 shift left by two and bits 1:0 become 0. The pairs are old 5:4, previous 3:2 and current 1:0, with the enable in the lower bit of each pair.
- R4: On `rfe_i` without `take_i`, status bits 3:0 take the old value of bits 5:2, and bits 5:4 keep their value.
- R5: When `take_i` and `rfe_i` arrive in the same cycle, only the push of R3 happens. In that cycle the push also overrides a port write to status bits 5:0.
- R6: On `take_i`, the faulting-address register (register 8) loads `badaddr_i` only when `code_i` is 4, 5, 6 or 7. Those are load/fetch address error, store address error, instruction bus error and data bus error. For any other code the register keeps its value.
- R7: Hardware pending flag i sits in cause bit 10+i. It sets at the edge that samples `hw_irq_i[i]`=1, whatever the enable and mask bits are. It stays set after the line drops, and it clears only when the line is low and a port write to cause carries 0 in that bit.
- R8: Cause bits 9:8 are software pending flags, written directly by a port write to cause (register 13).
- R9: `irq_o` is 1 exactly when some cause bit in 15:8 is set together with the status mask bit in the same position, and status bit 0 is 1.
- R10: Port writes never change the saved PC, the faulting-address register or the cause code field.
- R11: A port write to status (register 12) loads bits 15:8 (mask) and 5:0 (stack). All other bits of status and cause read 0. Reads of any register number other than 8, 12, 13 and 14 return 0.
- R12: `user_o` mirrors status bit 1 (1 means user mode) and `irq_en_o` mirrors status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Exception-take strobe |
| code_i | input | 4 | Exception code recorded on take |
| pc_i | input | 32 | Program counter of the successor instruction |
| badaddr_i | input | 32 | Address of the faulting memory reference |
| hw_irq_i | input | 6 | External interrupt request lines |
| rfe_i | input | 1 | Return-from-exception strobe |
| wr_en_i | input | 1 | Register port write enable |
| reg_num_i | input | 5 | Register number for read and write |
| wr_data_i | input | 32 | Register port write data |
| rd_data_o | output | 32 | Contents of the addressed register |
| epc_o | output | 32 | Saved program counter |
| cause_o | output | 32 | Cause word |
| status_o | output | 32 | Status word |
| badvaddr_o | output | 32 | Faulting-address register |
| user_o | output | 1 | Current mode, 1 = user |
| irq_en_o | output | 1 | Current interrupt enable |
| irq_o | output | 1 | Masked, enabled interrupt request |

## Verification
The bench targets the following cases:
- A take and a return in the same cycle. A design with the wrong priority pops the stack, or does both.
- A return after a nested take. A pop that shifts in zeros rather than keeping the old pair would leave the core in kernel mode with interrupts off on the outer return.
- A request pulse that arrives while interrupts are disabled. A level-following or enable-gated pending bit would lose the interrupt.
- Port writes aimed at the saved PC, the code field and the faulting-address register, which must stay untouched.
- Take strobes with codes outside the address and bus fault group, which must leave the faulting address as it was.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int REG_BADVADDR = 8;
   localparam int REG_STATUS   = 12;
   localparam int REG_CAUSE    = 13;
   localparam int REG_EPC      = 14;

   localparam int CODE_W = 4;

   typedef enum logic [CODE_W-1:0] {
      CODE_EXT_IRQ = 4'd0,
      CODE_ADDR_LD = 4'd4,
      CODE_ADDR_ST = 4'd5,
      CODE_IBUS    = 4'd6,
      CODE_DBUS    = 4'd7,
      CODE_SYSCALL = 4'd8,
      CODE_BREAK   = 4'd9,
      CODE_RSVD    = 4'd10,
      CODE_OVF     = 4'd12
   } exc_code_e;

   function automatic logic code_has_addr(input logic [CODE_W-1:0] c);
      return (c == CODE_ADDR_LD) || (c == CODE_ADDR_ST) ||
             (c == CODE_IBUS)    || (c == CODE_DBUS);
   endfunction

endpackage

// File: rtl/exc_status_stack.sv
module exc_status_stack #(
   parameter int XLEN    = 32,
   parameter int DEPTH   = 3,
   parameter int MASK_W  = 8,
   parameter int MASK_LO = 8,
   localparam int STK_W  = 2 * DEPTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic              wr_i,
   input  logic [XLEN-1:0]   wdata_i,
   output logic [STK_W-1:0]  stk_o,
   output logic [MASK_W-1:0] mask_o
);

   logic [STK_W-1:0]  stk_q;
   logic [MASK_W-1:0] mask_q;

   if (STK_W > MASK_LO) begin : g_bad_depth
      $error("status stack overlaps mask field");
   end
   if (MASK_LO + MASK_W > XLEN) begin : g_bad_mask
      $error("mask field exceeds word width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stk_q  <= '0;
         mask_q <= '0;
      end else begin
         if (push_i)
            stk_q <= {stk_q[STK_W-3:0], 2'b00};
         else if (pop_i)
            stk_q <= {stk_q[STK_W-1 -: 2], stk_q[STK_W-1:2]};
         else if (wr_i)
            stk_q <= wdata_i[STK_W-1:0];
         if (wr_i)
            mask_q <= wdata_i[MASK_LO +: MASK_W];
      end
   end

   assign stk_o  = stk_q;
   assign mask_o = mask_q;

   // R3
   stack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(push_i) |-> stk_q == {$past(stk_q[STK_W-3:0]), 2'b00});

   // R4
   stack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(pop_i) && !$past(push_i)
      |-> stk_q == {$past(stk_q[STK_W-1 -: 2]), $past(stk_q[STK_W-1:2])});

endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg #(
   parameter int XLEN    = 32,
   parameter int HW_IRQS = 6,
   parameter int SW_IRQS = 2,
   parameter int PEND_LO = 8,
   localparam int HW_LO  = PEND_LO + SW_IRQS,
   localparam int CW     = exc_pkg::CODE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic [CW-1:0]      code_i,
   input  logic [HW_IRQS-1:0] irq_i,
   input  logic               wr_i,
   input  logic [XLEN-1:0]    wdata_i,
   output logic [HW_IRQS-1:0] hwp_o,
   output logic [SW_IRQS-1:0] swp_o,
   output logic [CW-1:0]      code_o
);

   logic [HW_IRQS-1:0] hwp_q;
   logic [SW_IRQS-1:0] swp_q;
   logic [CW-1:0]      code_q;

   if (HW_LO + HW_IRQS > XLEN) begin : g_bad_pend
      $error("pending field exceeds word width");
   end

   for (genvar i = 0; i < HW_IRQS; i++) begin : g_hw
      logic keep;
      assign keep = wr_i ? (hwp_q[i] & wdata_i[HW_LO + i]) : hwp_q[i];
      always_ff @(posedge clk) begin
         if (!rst_n) hwp_q[i] <= 1'b0;
         else        hwp_q[i] <= keep | irq_i[i];
      end

      // R7
      pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(irq_i[i]) |-> hwp_q[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         swp_q  <= '0;
         code_q <= '0;
      end else begin
         if (wr_i)   swp_q  <= wdata_i[PEND_LO +: SW_IRQS];
         if (take_i) code_q <= code_i;
      end
   end

   assign hwp_o  = hwp_q;
   assign swp_o  = swp_q;
   assign code_o = code_q;

   // R10
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(take_i) |-> code_q == $past(code_q));

endmodule

// File: rtl/exc_fault_capture.sv
module exc_fault_capture #(
   parameter int XLEN    = 32,
   parameter int PC_STEP = 4,
   localparam int CW     = exc_pkg::CODE_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take_i,
   input  logic [CW-1:0]   code_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] badaddr_i,
   output logic [XLEN-1:0] epc_o,
   output logic [XLEN-1:0] badv_o
);

   logic [XLEN-1:0] epc_q, badv_q;
   logic            cap_addr;

   assign cap_addr = take_i && exc_pkg::code_has_addr(code_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q  <= '0;
         badv_q <= '0;
      end else begin
         if (take_i)   epc_q  <= pc_i - XLEN'(PC_STEP);
         if (cap_addr) badv_q <= badaddr_i;
      end
   end

   assign epc_o  = epc_q;
   assign badv_o = badv_q;

   // R10
   epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(take_i) |-> epc_q == $past(epc_q));

   // R6
   badv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !($past(take_i) && $past(code_i) inside {4'd4, 4'd5, 4'd6, 4'd7})
      |-> badv_q == $past(badv_q));

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
   parameter int XLEN      = 32,
   parameter int HW_IRQS   = 6,
   parameter int SW_IRQS   = 2,
   parameter int DEPTH     = 3,
   parameter int REG_NUM_W = 5,
   parameter int PC_STEP   = 4,
   localparam int IRQ_W    = HW_IRQS + SW_IRQS,
   localparam int PEND_LO  = 8,
   localparam int HW_LO    = PEND_LO + SW_IRQS,
   localparam int STK_W    = 2 * DEPTH,
   localparam int CW       = exc_pkg::CODE_W,
   localparam int CODE_LO  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take_i,
   input  logic [CW-1:0]        code_i,
   input  logic [XLEN-1:0]      pc_i,
   input  logic [XLEN-1:0]      badaddr_i,
   input  logic [HW_IRQS-1:0]   hw_irq_i,
   input  logic                 rfe_i,
   input  logic                 wr_en_i,
   input  logic [REG_NUM_W-1:0] reg_num_i,
   input  logic [XLEN-1:0]      wr_data_i,
   output logic [XLEN-1:0]      rd_data_o,
   output logic [XLEN-1:0]      epc_o,
   output logic [XLEN-1:0]      cause_o,
   output logic [XLEN-1:0]      status_o,
   output logic [XLEN-1:0]      badvaddr_o,
   output logic                 user_o,
   output logic                 irq_en_o,
   output logic                 irq_o
);

   if (IRQ_W != 8) begin : g_bad_irqs
      $error("hardware plus software levels must total 8");
   end
   if (XLEN < 16) begin : g_bad_xlen
      $error("word width too small for cause and status layout");
   end
   if (REG_NUM_W < 4) begin : g_bad_num
      $error("register number too narrow");
   end

   logic               wr_status, wr_cause;
   logic [STK_W-1:0]   stk;
   logic [IRQ_W-1:0]   mask;
   logic [HW_IRQS-1:0] hwp;
   logic [SW_IRQS-1:0] swp;
   logic [CW-1:0]      code;
   logic [IRQ_W-1:0]   pend;

   assign wr_status = wr_en_i && (reg_num_i == REG_NUM_W'(exc_pkg::REG_STATUS));
   assign wr_cause  = wr_en_i && (reg_num_i == REG_NUM_W'(exc_pkg::REG_CAUSE));

   exc_status_stack #(.XLEN(XLEN), .DEPTH(DEPTH), .MASK_W(IRQ_W), .MASK_LO(PEND_LO))
      u_status (
         .clk(clk), .rst_n(rst_n), .push_i(take_i), .pop_i(rfe_i),
         .wr_i(wr_status), .wdata_i(wr_data_i), .stk_o(stk), .mask_o(mask));

   exc_cause_reg #(.XLEN(XLEN), .HW_IRQS(HW_IRQS), .SW_IRQS(SW_IRQS), .PEND_LO(PEND_LO))
      u_cause (
         .clk(clk), .rst_n(rst_n), .take_i(take_i), .code_i(code_i),
         .irq_i(hw_irq_i), .wr_i(wr_cause), .wdata_i(wr_data_i),
         .hwp_o(hwp), .swp_o(swp), .code_o(code));

   exc_fault_capture #(.XLEN(XLEN), .PC_STEP(PC_STEP))
      u_fault (
         .clk(clk), .rst_n(rst_n), .take_i(take_i), .code_i(code_i),
         .pc_i(pc_i), .badaddr_i(badaddr_i), .epc_o(epc_o), .badv_o(badvaddr_o));

   always_comb begin
      status_o = '0;
      status_o[STK_W-1:0]       = stk;
      status_o[PEND_LO +: IRQ_W] = mask;
      cause_o = '0;
      cause_o[CODE_LO +: CW]      = code;
      cause_o[PEND_LO +: SW_IRQS] = swp;
      cause_o[HW_LO +: HW_IRQS]   = hwp;
   end

   assign pend     = {hwp, swp};
   assign user_o   = stk[1];
   assign irq_en_o = stk[0];
   assign irq_o    = stk[0] && |(pend & mask);

   always_comb begin
      case (int'(reg_num_i))
         exc_pkg::REG_BADVADDR: rd_data_o = badvaddr_o;
         exc_pkg::REG_STATUS:   rd_data_o = status_o;
         exc_pkg::REG_CAUSE:    rd_data_o = cause_o;
         exc_pkg::REG_EPC:      rd_data_o = epc_o;
         default:               rd_data_o = '0;
      endcase
   end

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> status_o[0]);

   // R2
   epc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(take_i) |-> epc_o == $past(pc_i) - XLEN'(PC_STEP));

endmodule

// File: tb/exc_state_regs_bench.sv
module exc_state_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take_i = 1'b0;
   logic [3:0]  code_i = '0;
   logic [31:0] pc_i = '0;
   logic [31:0] badaddr_i = '0;
   logic [5:0]  hw_irq_i = '0;
   logic        rfe_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [4:0]  reg_num_i = '0;
   logic [31:0] wr_data_i = '0;
   logic [31:0] rd_data_o, epc_o, cause_o, status_o, badvaddr_o;
   logic        user_o, irq_en_o, irq_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference model state
   logic [31:0] m_epc = '0, m_badv = '0;
   logic [3:0]  m_code = '0;
   logic [5:0]  m_hwp = '0, m_stk = '0;
   logic [1:0]  m_swp = '0;
   logic [7:0]  m_mask = '0;

   always #5 clk = ~clk;

   exc_state_regs u_exc_state_regs (
      .clk(clk), .rst_n(rst_n), .take_i(take_i), .code_i(code_i), .pc_i(pc_i),
      .badaddr_i(badaddr_i), .hw_irq_i(hw_irq_i), .rfe_i(rfe_i), .wr_en_i(wr_en_i),
      .reg_num_i(reg_num_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
      .epc_o(epc_o), .cause_o(cause_o), .status_o(status_o), .badvaddr_o(badvaddr_o),
      .user_o(user_o), .irq_en_o(irq_en_o), .irq_o(irq_o));

   function automatic logic [31:0] exp_status();
      return {16'h0, m_mask, 2'b00, m_stk};
   endfunction

   function automatic logic [31:0] exp_cause();
      return {16'h0, m_hwp, m_swp, 2'b00, m_code, 2'b00};
   endfunction

   function automatic logic [31:0] exp_rd(input logic [4:0] n);
      case (n)
         5'd8:    return m_badv;
         5'd12:   return exp_status();
         5'd13:   return exp_cause();
         5'd14:   return m_epc;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic exp_irq();
      return m_stk[0] && |({m_hwp, m_swp} & m_mask);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_all();
      check("R2 epc", epc_o, m_epc);
      check("R3 status", status_o, exp_status());
      check("R7 cause", cause_o, exp_cause());
      check("R6 badvaddr", badvaddr_o, m_badv);
      check("R9 irq", {31'h0, irq_o}, {31'h0, exp_irq()});
      check("R11 rd_data", rd_data_o, exp_rd(reg_num_i));
      check("R12 mode", {30'h0, user_o, irq_en_o}, {30'h0, m_stk[1], m_stk[0]});
   endtask

   task automatic model_update();
      logic [5:0]  n_stk, n_hwp;
      logic [7:0]  n_mask;
      logic [1:0]  n_swp;
      logic        ws, wc;
      ws = wr_en_i && reg_num_i == 5'd12;
      wc = wr_en_i && reg_num_i == 5'd13;
      n_stk  = take_i ? {m_stk[3:0], 2'b00} :
               rfe_i  ? {m_stk[5:4], m_stk[5:2]} :
               ws     ? wr_data_i[5:0] : m_stk;
      n_mask = ws ? wr_data_i[15:8] : m_mask;
      n_hwp  = (wc ? (m_hwp & wr_data_i[15:10]) : m_hwp) | hw_irq_i;
      n_swp  = wc ? wr_data_i[9:8] : m_swp;
      if (take_i) begin
         m_code = code_i;
         m_epc  = pc_i - 32'd4;
         if (code_i inside {4'd4, 4'd5, 4'd6, 4'd7}) m_badv = badaddr_i;
      end
      m_stk = n_stk; m_mask = n_mask; m_hwp = n_hwp; m_swp = n_swp;
   endtask

   // inputs are set before calling; clocks one edge and checks at negedge
   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      check_all();
   endtask

   task automatic idle();
      take_i = 0; rfe_i = 0; wr_en_i = 0; hw_irq_i = '0;
   endtask

   task automatic do_write(input logic [4:0] n, input logic [31:0] d);
      idle(); wr_en_i = 1; reg_num_i = n; wr_data_i = d; step(); idle();
   endtask

   task automatic do_take(input logic [3:0] c, input logic [31:0] pc, input logic [31:0] ba);
      idle(); take_i = 1; code_i = c; pc_i = pc; badaddr_i = ba; step(); idle();
   endtask

   function automatic logic [3:0] pick_code(input int unsigned r);
      case (r % 9)
         0: return 4'd0;  1: return 4'd4;  2: return 4'd5;
         3: return 4'd6;  4: return 4'd7;  5: return 4'd8;
         6: return 4'd9;  7: return 4'd10; default: return 4'd12;
      endcase
   endfunction

   function automatic logic [4:0] pick_reg(input int unsigned r);
      case (r % 6)
         0: return 5'd8;  1: return 5'd12; 2: return 5'd13;
         3: return 5'd14; 4: return 5'd12; default: return 5'd3;
      endcase
   endfunction

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 status reset", status_o, 32'h0);
      check("R1 cause reset", cause_o, 32'h0);
      check("R1 epc reset", epc_o, 32'h0);
      check("R1 irq reset", {29'h0, irq_o, user_o, irq_en_o}, 32'h0);

      // R11 status write keeps only mask and stack
      do_write(5'd12, 32'hABCD_FFFF);
      check("R11 status mask", status_o, 32'h0000_FF3F);
      check("R12 user/en", {30'h0, user_o, irq_en_o}, 32'h3);

      // R2 R3 take with overflow code
      do_take(4'd12, 32'h0000_1000, 32'h1111_2222);
      check("R2 epc minus step", epc_o, 32'h0000_0FFC);
      check("R2 code field", cause_o & 32'h3C, 32'h30);
      check("R3 stack push", status_o[5:0], 32'h3C);
      check("R6 no capture on ovf", badvaddr_o, 32'h0);

      // R6 address-error take captures
      do_take(4'd4, 32'h0000_2000, 32'h0000_DEAD);
      check("R6 capture", badvaddr_o, 32'h0000_DEAD);
      check("R3 nested push", status_o[5:0], 32'h30);

      // R4 pop keeps old pair
      idle(); rfe_i = 1; step(); idle();
      check("R4 pop", status_o[5:0], 32'h3C);

      // R5 take and rfe together: push only
      idle(); take_i = 1; rfe_i = 1; code_i = 4'd8; pc_i = 32'h40; step(); idle();
      check("R5 take wins", status_o[5:0], 32'h30);

      // R5 take overrides a same-cycle status write to the stack
      idle(); take_i = 1; code_i = 4'd9; pc_i = 32'h80;
      wr_en_i = 1; reg_num_i = 5'd12; wr_data_i = 32'h0000_AA15; step(); idle();
      check("R5 take over write", status_o, 32'h0000_AA00);

      // R10 port writes to read-only fields ignored
      do_write(5'd14, 32'hFFFF_FFFF);
      check("R10 epc ro", epc_o, 32'h0000_007C);
      do_write(5'd8, 32'h1234_5678);
      check("R10 badv ro", badvaddr_o, 32'h0000_DEAD);
      do_write(5'd13, 32'h0000_003C);
      check("R10 code ro", cause_o[5:2], 32'h9);

      // R7 pending sets while disabled and is sticky
      do_write(5'd12, 32'h0000_0400);
      idle(); hw_irq_i = 6'b000001; step(); idle(); step();
      check("R7 pending sticky", cause_o[10], 32'h1);
      check("R9 disabled no irq", {31'h0, irq_o}, 32'h0);
      do_write(5'd12, 32'h0000_0401);
      check("R9 enabled irq", {31'h0, irq_o}, 32'h1);
      do_write(5'd12, 32'h0000_0001);
      check("R9 masked no irq", {31'h0, irq_o}, 32'h0);
      do_write(5'd13, 32'h0);
      check("R7 pending cleared", cause_o[15:8], 32'h0);

      // R8 software pending write
      do_write(5'd13, 32'h0000_0300);
      check("R8 sw pending", cause_o[9:8], 32'h3);
      do_write(5'd12, 32'h0000_0201);
      check("R8 sw irq", {31'h0, irq_o}, 32'h1);

      // constrained random
      for (int k = 0; k < 3000; k++) begin
         int unsigned r;
         r = $urandom;
         take_i    = (r[2:0] == 3'd0);
         rfe_i     = (r[5:3] == 3'd1);
         wr_en_i   = (r[7:6] == 2'd0);
         reg_num_i = pick_reg($urandom);
         wr_data_i = $urandom;
         code_i    = pick_code($urandom);
         pc_i      = $urandom;
         badaddr_i = $urandom;
         hw_irq_i  = 6'($urandom & $urandom & $urandom);
         step();
      end
      idle();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule